// File: doc/BRIEF.md
# Hardware Address Breakpoint Matcher

This block watches a processor's bus accesses for debug breakpoints. It holds four watched addresses, one control word and one status word. Each cycle it compares a presented access against the four entries. An access is described by its address, its size (1, 2, 4 or 8 bytes) and its kind: instruction fetch, data read, data write or I/O.

Each entry has its own enables, an access-type field and a length field, all held in the control word. When an access hits one or more enabled entries, the block sets the matching status bits. In the following cycle it raises a single trap pulse together with a vector naming the entries that hit. The status bits are sticky and only software can clear them. A task-switch pulse clears the per-task (local) enables and leaves the global ones alone.

Software reaches the registers through a simple select/write-enable port with a combinational read path. The trap pulse goes to the exception logic, which is outside this block.

Top module: `bkpt_match`

## Requirements
- R1: Select 0–3 address the four watched-address registers, select 4 the control word and select 5 the status word. A write with `reg_we_i` updates the selected register at the next edge and `reg_rdata_o` shows it combinationally. Status reads back in bits [3:0] with the upper bits zero. Selects 6 and 7 read as zero and writes to them change nothing. All registers reset to zero.
- R2: Entry i takes part in matching only when its local enable (control bit 2i) or its global enable (control bit 2i+1) is set.
- R3: A `task_sw_i` pulse clears control bits 0, 2, 4 and 6 at the next edge and leaves bits 1, 3, 5 and 7 unchanged. If software writes the control word in the same cycle, the written value is stored with its local bits cleared.
- R4: The type field of entry i sits at control bits [17+4i:16+4i]. Code 00 matches fetches only, 01 matches data writes only, and 11 matches data reads and writes. Code 10 never matches. I/O accesses (kind 3) never match any entry.
- R5: The length field of entry i sits at control bits [19+4i:18+4i]. Code 00 means 1 byte, 01 means 2, 11 means 4 and 10 means 8. The watched range starts at the stored address with its low bits cleared to that length.
- R6: `acc_size_i` codes 0–3 mean 1, 2, 4 and 8 bytes starting at `acc_addr_i`. An entry hits when this byte range overlaps its watched range. `acc_kind_i` codes are 0 fetch, 1 read, 2 write and 3 I/O.
- R7: A hit on entry i sets status bit i at the next edge. When several entries hit on the same access, all of their bits are set together.
- R8: `trap_o` is high for exactly the one cycle after an access that hit at least one entry. `hit_o` shows the entries that hit in that same cycle and is zero otherwise.
- R9: Hardware never clears a status bit. Only a software write of zero does.
- R10: A status write in the same cycle as a hit stores the written value ORed with the new hits.
- R11: When `acc_valid_i` is low, nothing matches: no trap, no hit vector and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Read data of the selected register |
| task_sw_i | input | 1 | Task-switch pulse |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | AW | Access start address |
| acc_size_i | input | 2 | Access size code |
| acc_kind_i | input | 2 | Access kind code |
| trap_o | output | 1 | Debug trap pulse |
| hit_o | output | 4 | Entries that hit on the previous access |

## Verification
Directed accesses are placed just inside and just outside each watched range, at every length code. These separate correct base alignment and overlap from off-by-one range errors. The same address is then presented as a fetch, a read, a write and an I/O access, which isolates each type code, including the code that must never match. Further cases cover overlapping entries hit together, a status write colliding with a hit, and a task switch with and without a same-cycle control write; these expose priority mistakes. A long run of random accesses clustered around the watched addresses is then compared against the behavioural model on every cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NBP        = 4;
  localparam int CTRL_W     = 32;
  localparam int TYPE_LSB   = 16;
  localparam int LEN_LSB    = 18;
  localparam int FLD_STRIDE = 4;
  localparam int SEL_W      = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_IO    = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    BT_EXEC  = 2'b00,
    BT_WRITE = 2'b01,
    BT_IO    = 2'b10,
    BT_RW    = 2'b11
  } bp_type_e;

  // length field code -> bytes (10 is eight, 11 is four)
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic [CTRL_W-1:0] local_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < NBP; i++) m[2*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en_local_i,
  input  logic          en_global_i,
  input  logic [1:0]    type_i,
  input  logic [1:0]    len_i,
  input  logic [AW-1:0] base_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_size_i,
  input  logic [1:0]    acc_kind_i,
  output logic          hit_o
);
  localparam int XW = AW + 1;

  logic [AW-1:0] wlen, wmask, wbase;
  logic [XW-1:0] w_lo, w_hi, a_lo, a_hi;
  logic          overlap, kind_ok;

  always_comb begin
    wlen  = AW'(len_bytes(len_i));
    wmask = ~(wlen - AW'(1));
    wbase = base_i & wmask;
    w_lo  = {1'b0, wbase};
    w_hi  = w_lo + XW'(len_bytes(len_i));
    a_lo  = {1'b0, acc_addr_i};
    a_hi  = a_lo + XW'(size_bytes(acc_size_i));
    overlap = (a_lo < w_hi) && (w_lo < a_hi);
  end

  always_comb begin
    case (bp_type_e'(type_i))
      BT_EXEC:  kind_ok = (acc_kind_i == ACC_FETCH);
      BT_WRITE: kind_ok = (acc_kind_i == ACC_WRITE);
      BT_RW:    kind_ok = (acc_kind_i == ACC_READ) || (acc_kind_i == ACC_WRITE);
      default:  kind_ok = 1'b0;
    endcase
  end

  assign hit_o = acc_valid_i && (en_local_i || en_global_i) && kind_ok && overlap;
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [AW-1:0]           wdata_i,
  input  logic                    task_sw_i,
  input  logic [NBP-1:0]          hit_i,
  output logic [NBP-1:0][AW-1:0]  addr_o,
  output logic [CTRL_W-1:0]       ctrl_o,
  output logic [NBP-1:0]          status_o,
  output logic [AW-1:0]           rdata_o
);
  localparam logic [CTRL_W-1:0] LMASK = local_mask();

  logic [CTRL_W-1:0] ctrl_d;
  logic [NBP-1:0]    stat_d;

  for (genvar i = 0; i < NBP; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  addr_o[i] <= '0;
      else if (we_i && sel_i == SEL_W'(i))          addr_o[i] <= wdata_i;
    end
  end

  always_comb begin
    ctrl_d = (we_i && sel_i == SEL_CTRL) ? wdata_i[CTRL_W-1:0] : ctrl_o;
    if (task_sw_i) ctrl_d = ctrl_d & ~LMASK;
    // write wins, but hits of this cycle are never lost
    stat_d = ((we_i && sel_i == SEL_STAT) ? wdata_i[NBP-1:0] : status_o) | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      status_o <= '0;
    end else begin
      ctrl_o   <= ctrl_d;
      status_o <= stat_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i < SEL_W'(NBP))    rdata_o = addr_o[sel_i[1:0]];
    else if (sel_i == SEL_CTRL) rdata_o = AW'(ctrl_o);
    else if (sel_i == SEL_STAT) rdata_o = AW'(status_o);
  end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [AW-1:0]    reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  input  logic             task_sw_i,
  input  logic             acc_valid_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic [1:0]       acc_size_i,
  input  logic [1:0]       acc_kind_i,
  output logic             trap_o,
  output logic [NBP-1:0]   hit_o
);
  logic [NBP-1:0][AW-1:0] addr_w;
  logic [CTRL_W-1:0]      ctrl_w;
  logic [NBP-1:0]         status_w;
  logic [NBP-1:0]         hit_w;

  bkpt_regs #(.AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .task_sw_i(task_sw_i),
    .hit_i    (hit_w),
    .addr_o   (addr_w),
    .ctrl_o   (ctrl_w),
    .status_o (status_w),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    bkpt_cmp #(.AW(AW)) u_cmp (
      .en_local_i (ctrl_w[2*i]),
      .en_global_i(ctrl_w[2*i+1]),
      .type_i     (ctrl_w[TYPE_LSB + FLD_STRIDE*i +: 2]),
      .len_i      (ctrl_w[LEN_LSB + FLD_STRIDE*i +: 2]),
      .base_i     (addr_w[i]),
      .acc_valid_i(acc_valid_i),
      .acc_addr_i (acc_addr_i),
      .acc_size_i (acc_size_i),
      .acc_kind_i (acc_kind_i),
      .hit_o      (hit_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o <= 1'b0;
      hit_o  <= '0;
    end else begin
      trap_o <= |hit_w;
      hit_o  <= hit_w;
    end
  end
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk
  import bkpt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic              task_sw_i,
  input logic              acc_valid_i,
  input logic              trap_o,
  input logic [NBP-1:0]    hit_o,
  input logic [CTRL_W-1:0] ctrl_w,
  input logic [NBP-1:0]    status_w
);
  localparam logic [CTRL_W-1:0] LMASK = local_mask();
  localparam logic [CTRL_W-1:0] GMASK = LMASK << 1;

  // R3
  local_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_sw_i |=> (ctrl_w & LMASK) == '0);

  // R3
  global_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_sw_i && !(reg_we_i && reg_sel_i == SEL_CTRL))
      |=> (ctrl_w & GMASK) == ($past(ctrl_w) & GMASK));

  // R9
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_sel_i == SEL_STAT)
      |=> (status_w & $past(status_w)) == $past(status_w));

  // R8
  trap_has_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == (hit_o != '0));

  // R7
  hit_in_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (status_w & hit_o) == hit_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !trap_o && hit_o == '0);
endmodule

bind bkpt_match bkpt_match_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .task_sw_i  (task_sw_i),
  .acc_valid_i(acc_valid_i),
  .trap_o     (trap_o),
  .hit_o      (hit_o),
  .ctrl_w     (ctrl_w),
  .status_w   (status_w)
);

// File: tb/bkpt_match_test.sv
`timescale 1ns/1ps
module bkpt_match_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    sel = '0;
  logic [AW-1:0] wdata = '0;
  logic [AW-1:0] rdata;
  logic          tsw = 1'b0;
  logic          valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = '0;
  logic [1:0]    kind = '0;
  logic          trap;
  logic [3:0]    hit;

  always #2.5 clk = ~clk;

  bkpt_match #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .task_sw_i(tsw),
    .acc_valid_i(valid), .acc_addr_i(addr), .acc_size_i(size),
    .acc_kind_i(kind), .trap_o(trap), .hit_o(hit)
  );

  // behavioural reference state
  longint unsigned m_addr [4];
  logic [31:0]     m_ctrl;
  logic [3:0]      m_stat;
  logic            m_trap;
  logic [3:0]      m_hit;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  function automatic int len_of(input logic [1:0] c);
    case (c) 2'b00: return 1; 2'b01: return 2; 2'b10: return 8; default: return 4; endcase
  endfunction

  function automatic logic [3:0] model_hits();
    logic [3:0] h = '0;
    if (!valid) return h;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] t = m_ctrl[16+4*i +: 2];
      int L = len_of(m_ctrl[18+4*i +: 2]);
      longint unsigned base = m_addr[i] - (m_addr[i] % L);
      longint unsigned a = addr;
      longint unsigned s = 1 << size;
      bit en = m_ctrl[2*i] || m_ctrl[2*i+1];
      bit tok = (t == 2'b00 && kind == 2'd0) || (t == 2'b01 && kind == 2'd2) ||
                (t == 2'b11 && (kind == 2'd1 || kind == 2'd2));
      if (en && tok && a < base + L && base < a + s) h[i] = 1'b1;
    end
    return h;
  endfunction

  function automatic logic [AW-1:0] model_read();
    if (sel < 4) return AW'(m_addr[sel]);
    if (sel == 4) return m_ctrl;
    if (sel == 5) return AW'(m_stat);
    return '0;
  endfunction

  task automatic compare(input string req);
    vectors++;
    if (trap !== m_trap || hit !== m_hit) begin
      errors++;
      $display("FAIL %s trap/hit actual %b/%b expected %b/%b", req, trap, hit, m_trap, m_hit);
    end
    vectors++;
    if (rdata !== model_read()) begin
      errors++;
      $display("FAIL %s rdata sel %0d actual %h expected %h", req, sel, rdata, model_read());
    end
  endtask

  // inputs are already driven; advance one clock, update model, check at negedge
  task automatic step(input string req);
    logic [3:0] hv;
    @(posedge clk);
    hv = model_hits();
    m_stat = ((we && sel == 5) ? wdata[3:0] : m_stat) | hv;
    if (we && sel == 4) m_ctrl = wdata;
    if (tsw) m_ctrl = m_ctrl & ~32'h55;
    if (we && sel < 4) m_addr[sel] = wdata;
    m_trap = |hv;
    m_hit = hv;
    @(negedge clk);
    compare(req);
    we = 0; tsw = 0; valid = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [AW-1:0] d, input string req);
    we = 1; sel = s; wdata = d;
    step(req);
  endtask

  task automatic rd(input logic [2:0] s, input string req);
    sel = s;
    step(req);
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] k, input string req);
    valid = 1; addr = a; size = sz; kind = k; sel = 3'd5;
    step(req);
  endtask

  // ctrl field helper: type, len for entry i
  function automatic logic [31:0] fld(input int i, input logic [1:0] t, input logic [1:0] l);
    return (32'(t) << (16 + 4*i)) | (32'(l) << (18 + 4*i));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    for (int i = 0; i < 4; i++) m_addr[i] = 0;
    m_ctrl = 0; m_stat = 0; m_trap = 0; m_hit = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    for (int s = 0; s < 8; s++) rd(3'(s), "R1 reset readback");

    // R1 register programming and unmapped selects
    wr(0, 32'h1000, "R1"); wr(1, 32'h2003, "R1");
    wr(2, 32'h3005, "R1"); wr(3, 32'h4000, "R1");
    wr(6, 32'hdead_beef, "R1 unmapped write");
    wr(7, 32'h1234_5678, "R1 unmapped write");
    for (int s = 0; s < 8; s++) rd(3'(s), "R1 readback");

    // entry0 global exec 1B, entry1 local write 2B, entry2 global rw 4B, entry3 global io 8B
    c = 32'h0000_00a6 | fld(0, 2'b00, 2'b00) | fld(1, 2'b01, 2'b01)
                      | fld(2, 2'b11, 2'b11) | fld(3, 2'b10, 2'b10);
    c[0] = 0; c[1] = 1; c[2] = 1; c[3] = 0; c[4] = 0; c[5] = 1; c[6] = 0; c[7] = 1;
    wr(4, c, "R2");
    acc(32'h1000, 0, 0, "R4 fetch hits exec entry");
    acc(32'h1000, 0, 1, "R4 read misses exec entry");
    acc(32'h1000, 0, 2, "R4 write misses exec entry");
    acc(32'h0fff, 0, 0, "R6 fetch below exec entry");
    acc(32'h2001, 1, 2, "R5 2B write overlaps aligned base");
    acc(32'h2000, 1, 2, "R5 2B write just below range");
    acc(32'h2004, 0, 2, "R5 write just above range");
    acc(32'h2002, 0, 1, "R4 read misses write-only entry");
    acc(32'h3007, 0, 1, "R5 read top byte of 4B range");
    acc(32'h3004, 0, 2, "R5 write base of 4B range");
    acc(32'h3008, 0, 1, "R5 read above 4B range");
    acc(32'h3000, 2, 1, "R6 4B read below range");
    acc(32'h3000, 3, 1, "R6 8B read overlapping range");
    acc(32'h3004, 0, 3, "R4 io kind never matches");
    acc(32'h4003, 0, 2, "R4 type 10 never matches");
    // R2 disable entry2 both enables
    wr(4, c & ~32'h30, "R2 entry2 disabled");
    acc(32'h3004, 0, 1, "R2 disabled entry silent");
    wr(4, c, "R2");
    // R11 valid low
    valid = 0; addr = 32'h1000; kind = 0; sel = 5; step("R11 invalid access ignored");
    // R9 software clears status, hardware keeps it
    rd(5, "R9 status held");
    rd(5, "R9 status held");
    wr(5, 32'h0, "R9 software clear");
    // R7 multi-hit: entry3 rw 8B at 0x4000, entry2 moved to 0x4004
    wr(2, 32'h4004, "R7");
    wr(4, (c & ~fld(3, 2'b11, 2'b11)) | fld(3, 2'b11, 2'b10), "R7");
    acc(32'h4005, 0, 1, "R7 two entries hit together");
    acc(32'h4001, 0, 1, "R7 single entry hit");
    acc(32'h4007, 1, 2, "R8 back-to-back hits");
    // R10 status write same cycle as hit
    we = 1; sel = 5; wdata = 32'h1; valid = 1; addr = 32'h4004; size = 0; kind = 1;
    step("R10 write ORed with hit");
    rd(5, "R10 readback");
    // R3 task switch: local entry1 cleared, globals kept
    tsw = 1; sel = 4; step("R3 task switch");
    acc(32'h2002, 0, 2, "R3 local entry no longer hits");
    acc(32'h1000, 0, 0, "R3 global entry still hits");
    we = 1; sel = 4; wdata = 32'h0000_00ff | fld(1, 2'b01, 2'b01); tsw = 1;
    step("R3 write plus task switch");
    rd(4, "R3 readback");

    // random traffic near watched addresses
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) begin
        we = 1; sel = 3'($urandom_range(0, 7));
        wdata = (sel == 4) ? $urandom : (sel < 4 ? 32'h1000 * $urandom_range(1, 4) + $urandom_range(0, 15) : $urandom);
      end else if (r == 1) begin
        tsw = 1;
      end else begin
        sel = 3'($urandom_range(0, 7));
      end
      valid = ($urandom_range(0, 3) != 0);
      addr = 32'h1000 * $urandom_range(1, 4) + $urandom_range(0, 20) - 2;
      size = 2'($urandom_range(0, 3));
      kind = 2'($urandom_range(0, 3));
      step("R6 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule